// File: doc/BRIEF.md
# Mode-Configurable Parallel-to-Serial Multiplexer

This block converts a 40-bit low-speed word into serial streams on up to eight high-speed lanes. A 3-bit mode input selects one of eight serialization ratios, from 4:1 to 40:1. Each ratio comes with a fixed assignment of bus bits to lanes. Every lane sends its slice least significant bit first.

Load and shift timing can come from two places. In internal mode, an on-block counter latches each new word and reloads the lane shift registers once per word, which gives a continuous stream with no gaps. In external mode, three strobes supplied by the surrounding logic take over latching, loading and shifting. In this mode lane 0 can also be filled bit by bit from a serial input. An output-phase select chooses whether the lane outputs change on the rising or the falling clock edge. A forwarded copy of the clock is provided alongside the data.

Top module: `vsr_mux`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the word counter, the holding register and all shift registers, so every `dout` bit reads 0 after that edge. Internal timing then restarts from its first word.
- R2: Mode 000 drives all 8 lanes at 4:1, with lane k sending bus bits 4k..4k+3. Mode 001 drives all 8 lanes at 5:1, with lane k sending bits 5k..5k+4.
- R3: Mode 010 runs at 8:1 on lanes 0, 2, 4 and 6 (bits 0-7, 8-15, 16-23, 24-31) and on lane 7 (bits 32-39). Mode 011 runs at 10:1 on lanes 0, 2, 4 and 6 (bits 0-9, 10-19, 20-29, 30-39).
- R4: Mode 100 runs at 16:1 with lane 0 sending bits 0-15 and lane 6 sending bits 16-31. Mode 101 runs at 20:1 with lane 0 sending bits 0-19 and lane 4 sending bits 20-39. Mode 110 sends bits 0-31 on lane 0 at 32:1. Mode 111 sends bits 0-39 on lane 0 at 40:1.
- R5: With `int_mode` high, the word on `din` is sampled once every R cycles, where R is the ratio. The first sample is taken at the R-th rising edge after reset. Its lowest slice bit appears on the lane at the next edge. Later bits follow one per edge, lowest first, and the next word follows with no gap.
- R6: Lanes that the selected mode does not use are driven 0.
- R7: With `ops` low, `dout` changes just after the rising clock edge. With `ops` high, it changes half a cycle later, on the falling edge. `clk_out` follows `clk` whatever `ops` is.
- R8: With `int_mode` low:
  - A rising edge with `ld_hold_n` low captures `din`; `din` is ignored otherwise.
  - A rising edge with `ld_sr_n` low loads the lane registers from the captured word; this takes priority over shifting.
  - With `ld_sr_n` high and `shf_en` high, each edge advances every lane by one bit, and bits beyond the ratio read 0.
- R9: With `int_mode` low, `ld_sr_n` high and `shf_en` low, each rising edge moves `sin` into lane 0 at position R-1 while lane 0 shifts down. After R edges, the first captured bit is on `dout[0]`, and `shf_en` high then sends the rest in capture order. Lanes 1 to 7 hold their state during this fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed bit clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Ratio and lane-mapping select |
| int_mode | input | 1 | 1 = internal timing, 0 = external strobes |
| ld_hold_n | input | 1 | External word capture strobe, active low |
| ld_sr_n | input | 1 | External shift-register load strobe, active low |
| shf_en | input | 1 | External shift enable, active high |
| sin | input | 1 | Serial input into lane 0 |
| ops | input | 1 | Output edge select: 0 rising, 1 falling |
| din | input | 40 | Low-speed parallel word |
| dout | output | 8 | High-speed lane outputs |
| clk_out | output | 1 | Forwarded clock |

## Verification
The properties assume that `mode`, `ops` and the external strobes change only between rising edges and stay steady across each edge. They also assume that `rst` is asserted for at least one edge before any check is meaningful. The stimulus applies every input change on the falling edge. It switches `mode` and `int_mode` only while reset is held. It leaves `ops` fixed for a whole test, so the falling-edge capture always sees a settled rising-edge value.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

    typedef enum logic [2:0] {
        M_4X8  = 3'd0,
        M_5X8  = 3'd1,
        M_8X5  = 3'd2,
        M_10X4 = 3'd3,
        M_16X2 = 3'd4,
        M_20X2 = 3'd5,
        M_32X1 = 3'd6,
        M_40X1 = 3'd7
    } mode_e;

    // serialization ratio (bits per lane per word)
    function automatic int ratio_of(input logic [2:0] m);
        case (mode_e'(m))
            M_4X8:   return 4;
            M_5X8:   return 5;
            M_8X5:   return 8;
            M_10X4:  return 10;
            M_16X2:  return 16;
            M_20X2:  return 20;
            M_32X1:  return 32;
            default: return 40;
        endcase
    endfunction

    // lane k carries data in mode m
    function automatic bit lane_on(input logic [2:0] m, input int k);
        case (mode_e'(m))
            M_4X8, M_5X8: return (k >= 0) && (k < 8);
            M_8X5:        return (k == 0) || (k == 2) || (k == 4) || (k == 6) || (k == 7);
            M_10X4:       return (k == 0) || (k == 2) || (k == 4) || (k == 6);
            M_16X2:       return (k == 0) || (k == 6);
            M_20X2:       return (k == 0) || (k == 4);
            default:      return (k == 0);
        endcase
    endfunction

    // first bus bit of lane k's slice in mode m
    function automatic int lane_base(input logic [2:0] m, input int k);
        case (mode_e'(m))
            M_4X8:   return 4 * k;
            M_5X8:   return 5 * k;
            M_8X5:   return (k == 7) ? 32 : 4 * k;
            M_10X4:  return 5 * k;
            M_16X2:  return (k == 6) ? 16 : 0;
            M_20X2:  return (k == 4) ? 20 : 0;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/vsr_timing.sv
module vsr_timing #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             int_mode,
    input  logic [CNT_W-1:0] ratio,
    input  logic             ld_hold_n,
    input  logic             ld_sr_n,
    input  logic             shf_en,
    output logic             latch_en,
    output logic             load_en,
    output logic             shift_en,
    output logic             fill_en
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tg_t;

    tg_t st_d, st_q;
    logic [CNT_W-1:0] last_cnt;

    assign last_cnt = ratio - CNT_W'(1);

    always_comb begin
        st_d     = st_q;
        latch_en = 1'b0;
        load_en  = 1'b0;
        shift_en = 1'b0;
        fill_en  = 1'b0;
        if (int_mode) begin
            // word boundary: capture at the last count, reload at count zero
            latch_en = (st_q.cnt == last_cnt);
            load_en  = (st_q.cnt == '0);
            shift_en = !load_en;
            st_d.cnt = (st_q.cnt >= last_cnt) ? '0 : st_q.cnt + CNT_W'(1);
        end else begin
            latch_en = !ld_hold_n;
            load_en  = !ld_sr_n;
            shift_en = ld_sr_n && shf_en;
            fill_en  = ld_sr_n && !shf_en;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/vsr_lanes.sv
module vsr_lanes #(
    parameter int BUS_W = 40,
    parameter int LANES = 8,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode,
    input  logic [CNT_W-1:0] ratio,
    input  logic [BUS_W-1:0] din,
    input  logic             latch_en,
    input  logic             load_en,
    input  logic             shift_en,
    input  logic             fill_en,
    input  logic             sin,
    output logic [LANES-1:0] rise_bits
);

    typedef struct packed {
        logic [BUS_W-1:0]             hold;
        logic [LANES-1:0][BUS_W-1:0]  sh;
    } ln_t;

    ln_t st_d, st_q;
    logic [BUS_W-1:0] slice;

    always_comb begin
        st_d  = st_q;
        slice = '0;
        if (latch_en) st_d.hold = din;
        for (int k = 0; k < LANES; k++) begin
            if (load_en) begin
                // load takes the word held before this edge
                slice = st_q.hold >> vsr_pkg::lane_base(mode, k);
                for (int i = 0; i < BUS_W; i++) begin
                    st_d.sh[k][i] = vsr_pkg::lane_on(mode, k) && (i < int'(ratio)) && slice[i];
                end
            end else if (shift_en) begin
                st_d.sh[k] = st_q.sh[k] >> 1;
            end else if (fill_en && (k == 0)) begin
                for (int i = 0; i < BUS_W; i++) begin
                    if (i == int'(ratio) - 1)     st_d.sh[k][i] = sin;
                    else if (i < int'(ratio) - 1) st_d.sh[k][i] = st_q.sh[k][i+1];
                    else                          st_d.sh[k][i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_tap
        assign rise_bits[g] = st_q.sh[g][0];
    end

endmodule

// File: rtl/vsr_edge.sv
module vsr_edge #(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ops,
    input  logic [LANES-1:0] rise_bits,
    output logic [LANES-1:0] dout
);

    logic [LANES-1:0] fall_d, fall_q;

    always_comb fall_d = rise_bits;

    // half-cycle retimed copy of the lane bits
    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= fall_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_sel
        assign dout[g] = ops ? fall_q[g] : rise_bits[g];
    end

endmodule

// File: rtl/vsr_mux.sv
module vsr_mux #(
    parameter int BUS_W = 40,
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode,
    input  logic             int_mode,
    input  logic             ld_hold_n,
    input  logic             ld_sr_n,
    input  logic             shf_en,
    input  logic             sin,
    input  logic             ops,
    input  logic [BUS_W-1:0] din,
    output logic [LANES-1:0] dout,
    output logic             clk_out
);

    localparam int CNT_W = $clog2(BUS_W + 1);

    logic [CNT_W-1:0] ratio;
    logic             latch_en, load_en, shift_en, fill_en;
    logic [LANES-1:0] rise_bits;

    assign ratio   = CNT_W'(vsr_pkg::ratio_of(mode));
    assign clk_out = clk;

    vsr_timing #(.CNT_W(CNT_W)) tg_i (
        .clk(clk), .rst(rst), .int_mode(int_mode), .ratio(ratio),
        .ld_hold_n(ld_hold_n), .ld_sr_n(ld_sr_n), .shf_en(shf_en),
        .latch_en(latch_en), .load_en(load_en), .shift_en(shift_en), .fill_en(fill_en)
    );

    vsr_lanes #(.BUS_W(BUS_W), .LANES(LANES), .CNT_W(CNT_W)) ln_i (
        .clk(clk), .rst(rst), .mode(mode), .ratio(ratio), .din(din),
        .latch_en(latch_en), .load_en(load_en), .shift_en(shift_en),
        .fill_en(fill_en), .sin(sin), .rise_bits(rise_bits)
    );

    vsr_edge #(.LANES(LANES)) ed_i (
        .clk(clk), .rst(rst), .ops(ops), .rise_bits(rise_bits), .dout(dout)
    );

endmodule

// File: rtl/vsr_mux_chk.sv
module vsr_mux_chk #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             int_mode,
    input logic             ops,
    input logic             ld_sr_n,
    input logic             shf_en,
    input logic [2:0]       mode,
    input logic             latch_en,
    input logic             load_en,
    input logic [LANES-1:0] rise_bits,
    input logic [LANES-1:0] dout
);

    logic [LANES-1:0] on_mask;

    always_comb begin
        for (int k = 0; k < LANES; k++) on_mask[k] = vsr_pkg::lane_on(mode, k);
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (rise_bits == '0 && dout == '0));

    // R5
    word_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (int_mode && latch_en) |=> (load_en || !int_mode));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        int_mode |-> $onehot0({latch_en, load_en}));

    // R6
    idle_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> ((rise_bits & ~$past(on_mask)) == '0));

    // R7
    fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ops |-> (dout == rise_bits));

    // R9
    fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!int_mode && ld_sr_n && !shf_en) |=> (rise_bits[LANES-1:1] == $past(rise_bits[LANES-1:1])));

endmodule

bind vsr_mux vsr_mux_chk #(.LANES(LANES)) chk_i (
    .clk(clk), .rst(rst), .int_mode(int_mode), .ops(ops), .ld_sr_n(ld_sr_n),
    .shf_en(shf_en), .mode(mode), .latch_en(latch_en), .load_en(load_en),
    .rise_bits(rise_bits), .dout(dout)
);

// File: tb/vsr_mux_tb_top.sv
module vsr_mux_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = 3'd0;
    logic        int_mode = 1'b1;
    logic        ld_hold_n = 1'b1;
    logic        ld_sr_n = 1'b1;
    logic        shf_en = 1'b0;
    logic        sin = 1'b0;
    logic        ops = 1'b0;
    logic [39:0] din = '0;
    logic [7:0]  dout;
    logic        clk_out;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsr_mux dut_i (
        .clk(clk), .rst(rst), .mode(mode), .int_mode(int_mode),
        .ld_hold_n(ld_hold_n), .ld_sr_n(ld_sr_n), .shf_en(shf_en), .sin(sin),
        .ops(ops), .din(din), .dout(dout), .clk_out(clk_out)
    );

    // {mode, first word, second word}
    localparam logic [82:0] VECS [0:7] = '{
        {3'd0, 40'h9C5A3E71B4, 40'h36E1D80F5A},
        {3'd1, 40'hA53C960F1E, 40'h5AC369F0E1},
        {3'd2, 40'h0123456789, 40'hFEDCBA9876},
        {3'd3, 40'hC3A5F00F5A, 40'h3C5A0FF0A5},
        {3'd4, 40'h00B7E15163, 40'h0048D2C1A9},
        {3'd5, 40'h8D3F1C62E5, 40'h72C0E39D1A},
        {3'd6, 40'h00DEADBEEF, 40'h0013579BDF},
        {3'd7, 40'hF0C3A59617, 40'h0F3C5A69E8}
    };

    function automatic int exp_ratio(input logic [2:0] m);
        case (m)
            3'd0: return 4;   3'd1: return 5;   3'd2: return 8;   3'd3: return 10;
            3'd4: return 16;  3'd5: return 20;  3'd6: return 32;  default: return 40;
        endcase
    endfunction

    function automatic logic [7:0] exp_mask(input logic [2:0] m);
        case (m)
            3'd0, 3'd1: return 8'hFF;
            3'd2:       return 8'hD5;
            3'd3:       return 8'h55;
            3'd4:       return 8'h41;
            3'd5:       return 8'h11;
            default:    return 8'h01;
        endcase
    endfunction

    function automatic int exp_base(input logic [2:0] m, input int k);
        case (m)
            3'd0: return 4 * k;
            3'd1: return 5 * k;
            3'd2: return (k == 7) ? 32 : 4 * k;
            3'd3: return 10 * (k / 2);
            3'd4: return (k == 6) ? 16 : 0;
            3'd5: return (k == 4) ? 20 : 0;
            default: return 0;
        endcase
    endfunction

    // lane values when bit j (0 = lowest) of every slice is on the wire
    function automatic logic [7:0] exp_vec(input logic [2:0] m, input logic [39:0] w, input int j);
        logic [7:0] v;
        v = '0;
        for (int k = 0; k < 8; k++) begin
            if (exp_mask(m)[k]) v[k] = w[exp_base(m, k) + (j % exp_ratio(m))];
        end
        return v;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(dout, 8'h00, "R1 reset state");
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // stream vectors in internal mode: R2 R3 R4 R5 R6
        for (int v = 0; v < 8; v++) begin
            logic [2:0]  m;
            logic [39:0] w1, w2;
            int          r;
            string       tag;
            m  = VECS[v][82:80];
            w1 = VECS[v][79:40];
            w2 = VECS[v][39:0];
            r  = exp_ratio(m);
            tag = (m < 3'd2) ? "R2 R5 R6" : (m < 3'd4) ? "R3 R5 R6" : "R4 R5 R6";
            rst = 1'b1;
            mode = m; int_mode = 1'b1; ops = 1'b0; din = w1;
            do_reset();
            for (int e = 1; e <= 3 * r; e++) begin
                int j;
                logic [7:0] ex;
                @(negedge clk);
                j = e - (r + 1);
                if (j < 0)      ex = 8'h00;
                else if (j < r) ex = exp_vec(m, w1, j);
                else            ex = exp_vec(m, w2, j - r);
                chk(dout, ex, tag);
                if (j == 0) din = w2;
            end
        end

        // R1: reset mid-stream clears counter, so data needs a full word again
        rst = 1'b1; mode = 3'd0; din = '1;
        do_reset();
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(dout, 8'h00, "R1 mid-run reset");
        rst = 1'b0;
        for (int e = 1; e <= 5; e++) begin
            @(negedge clk);
            chk(dout, (e < 5) ? 8'h00 : 8'hFF, "R1 counter restart");
        end

        // R7: falling-edge launch, clock forwarding
        rst = 1'b1; mode = 3'd6; ops = 1'b1; din = 40'h00DEADBEEF;
        do_reset();
        for (int e = 1; e <= 45; e++) begin
            logic [7:0] prv, cur;
            prv = (e - 1 < 33) ? 8'h00 : exp_vec(3'd6, din, e - 1 - 33);
            cur = (e < 33) ? 8'h00 : exp_vec(3'd6, din, e - 33);
            @(posedge clk);
            #1;
            chk(dout, prv, "R7 held after rising edge");
            chk({7'd0, clk_out}, 8'h01, "R7 clk_out high");
            @(negedge clk);
            #1;
            chk(dout, cur, "R7 changed after falling edge");
            chk({7'd0, clk_out}, 8'h00, "R7 clk_out low");
        end
        ops = 1'b0;

        // R8: external capture, load, shift, hold, priority (mode 011, 10:1)
        rst = 1'b1; mode = 3'd3; int_mode = 1'b0;
        ld_hold_n = 1'b1; ld_sr_n = 1'b1; shf_en = 1'b0; sin = 1'b0;
        do_reset();
        din = 40'hC3A5F00F5A; ld_hold_n = 1'b0;
        @(negedge clk);
        ld_hold_n = 1'b1; din = 40'h3C5A0FF0A5; ld_sr_n = 1'b0;
        @(negedge clk);
        chk(dout, exp_vec(3'd3, 40'hC3A5F00F5A, 0), "R8 load captured word");
        ld_sr_n = 1'b1; shf_en = 1'b1;
        for (int j = 1; j <= 3; j++) begin
            @(negedge clk);
            chk(dout, exp_vec(3'd3, 40'hC3A5F00F5A, j), "R8 shift");
        end
        shf_en = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk({dout[7:1], 1'b0}, {exp_vec(3'd3, 40'hC3A5F00F5A, 3)[7:1], 1'b0}, "R9 other lanes hold");
        end
        shf_en = 1'b1;
        for (int j = 4; j <= 10; j++) begin
            @(negedge clk);
            chk({dout[7:1], 1'b0},
                (j < 10) ? {exp_vec(3'd3, 40'hC3A5F00F5A, j)[7:1], 1'b0} : 8'h00,
                "R8 shift resumes, zero past ratio");
        end
        ld_sr_n = 1'b0;
        @(negedge clk);
        chk(dout, exp_vec(3'd3, 40'hC3A5F00F5A, 0), "R8 load wins over shift, din ignored");
        ld_sr_n = 1'b1; shf_en = 1'b0;

        // R9: serial fill of lane 0 in mode 010 (8:1)
        rst = 1'b1; mode = 3'd2;
        do_reset();
        begin
            logic [7:0] s;
            s = 8'b1011_0010;
            for (int i = 0; i < 8; i++) begin
                sin = s[i];
                @(negedge clk);
            end
            chk(dout, {7'd0, s[0]}, "R9 first serial bit");
            shf_en = 1'b1;
            for (int k = 1; k < 8; k++) begin
                @(negedge clk);
                chk(dout, {7'd0, s[k]}, "R9 serial order");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule